// File: doc/BRIEF.md
# Programmable Third-Order Decimating Bitstream Filter

This block turns a one-bit oversampled bitstream into signed 24-bit words. It uses a third-order cascaded integrator-comb filter. A clock-enable strobe marks each modulator sample. Every sample adds +1 (bit high) or -1 (bit low) into a chain of three integrators. After a programmable number of samples, the integrator sum passes through three difference stages at the decimated rate. It is then scaled by a power of two and presented with a one-cycle valid pulse.

A 7-bit rate code selects the frame length. Ordinary codes give a frame of (code+1)×64 samples. The two highest codes give fixed frames of 8533 and 10240 samples, which produce 60 Hz and 50 Hz outputs from a 512 kHz sample rate. A configuration load pulse latches a new code and restarts the filter from a clean state. The first two outputs after any restart are marked as not yet settled. Codes below a parameterised floor, set to 1 by default for a shared three-channel path, are raised to that floor.

Top module: `sinc3_decim`

## Requirements
- R1: After a clock edge with `rst` high, `result_valid`, `result_settled` and `result` are all 0. The active code is 7, so the frame is 512 strobes.
- R2: For an effective code c from the floor up to 125, consecutive outputs are exactly (c+1)×64 accepted strobes apart. Cycles with `sample_en` low are neither counted nor integrated.
- R3: Code 126 gives a frame of 8533 accepted strobes.
- R4: Code 127 gives a frame of 10240 accepted strobes.
- R5: A code below `MIN_CODE` (default 1) acts as `MIN_CODE`, so code 0 gives 128-strobe frames.
- R6: At an edge with `cfg_load` high, the block does all of the following:
  - it latches `cfg_code`;
  - it clears the integrators, the combs, the frame counter and the settle tracking;
  - it discards the sample offered at that edge;
  - after that edge, `result_valid` is 0 and `result` is 0.
- R7: Each output equals the third-order moving sum of the ±1 samples over the frame length N, taken at the frame's last sample, with samples before the restart counted as 0. With k = ceil(log2 N), the sum is shifted arithmetically right by 3k−22 when that is ≥ 0, and otherwise shifted left by 22−3k. The result is a 24-bit two's-complement value.
- R8: If the edge at cycle n accepts a frame's last sample, `result_valid` is high for exactly the cycle between edges n+1 and n+2.
- R9: `result_settled` is high only together with `result_valid`. It is 0 on the first two outputs after a restart and 1 on every later output.
- R10: `result` keeps its value between valid pulses.
- R11: With N a power of two, a constant high input gives exactly +4194304 and a constant low input gives −4194304 from the third output on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Marks a cycle carrying a modulator sample |
| mod_bit | input | 1 | Modulator bit, 1 = +1, 0 = −1 |
| cfg_load | input | 1 | Latch `cfg_code` and restart the filter |
| cfg_code | input | 7 | Rate code |
| result | output | 24 | Signed filtered word |
| result_valid | output | 1 | One-cycle pulse marking a new word |
| result_settled | output | 1 | New word has passed the settling outputs |

## Verification
A behavioural reference computes cascaded moving sums from queues, and the bench compares `result` against it on every cycle. This catches a comb tap off by one frame, a wrong shift amount for non-power-of-two frames, or an integrator that keeps counting during idle strobes. Frame lengths are measured in accepted strobes for ordinary codes, the floored code 0, and both fixed-rate codes; a design that applied the ordinary formula to codes 126 or 127 would space its pulses 8128 or 8192 strobes apart. Reloads in the middle of a frame, including a sample offered on the load edge, expose a filter that keeps stale state or consumes that sample. Constant inputs check the exact full-scale value and whether the settled flag turns on one output too early or too late.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    localparam int CODE_W   = 7;
    localparam int OUT_W    = 24;
    localparam int ORDER    = 3;
    localparam int BASE_OSR = 64;
    localparam int CODE_60  = 126;
    localparam int CODE_50  = 127;
    localparam int RATIO_60 = 8533;
    localparam int RATIO_50 = 10240;
    localparam int RATIO_W  = $clog2(RATIO_50 + 1);
    localparam int LOG_MAX  = $clog2(RATIO_50);
    localparam int ACC_W    = ORDER * LOG_MAX + 1;
    localparam int FS_EXP   = OUT_W - 2;
    localparam int SHIFT_W  = 6;

    typedef logic [CODE_W-1:0]         code_t;
    typedef logic [RATIO_W-1:0]        ratio_t;
    typedef logic signed [ACC_W-1:0]   acc_t;
    typedef logic signed [OUT_W-1:0]   res_t;

    typedef struct packed {
        ratio_t               ratio;
        logic                 left;
        logic [SHIFT_W-1:0]   amt;
    } frame_cfg_t;

    typedef enum logic [1:0] {
        FILL_FIRST,
        FILL_SECOND,
        SETTLED
    } settle_e;

    function automatic logic [SHIFT_W-1:0] ceil_log2(input ratio_t v);
        logic [SHIFT_W-1:0] r;
        r = '0;
        for (int i = 0; i < RATIO_W; i++) begin
            if ((ratio_t'(1) << i) < v) r = SHIFT_W'(i + 1);
        end
        return r;
    endfunction

    function automatic frame_cfg_t decode_code(input code_t code, input code_t min_code);
        frame_cfg_t c;
        code_t      eff;
        int         total;
        eff = (code < min_code) ? min_code : code;
        if (eff == code_t'(CODE_50))
            c.ratio = ratio_t'(RATIO_50);
        else if (eff == code_t'(CODE_60))
            c.ratio = ratio_t'(RATIO_60);
        else
            c.ratio = ratio_t'((int'(eff) + 1) * BASE_OSR);
        total = ORDER * int'(ceil_log2(c.ratio));
        if (total >= FS_EXP) begin
            c.left = 1'b0;
            c.amt  = SHIFT_W'(total - FS_EXP);
        end else begin
            c.left = 1'b1;
            c.amt  = SHIFT_W'(FS_EXP - total);
        end
        return c;
    endfunction

    function automatic res_t scale_out(input acc_t v, input frame_cfg_t c);
        acc_t s;
        s = c.left ? (v <<< c.amt) : (v >>> c.amt);
        return s[OUT_W-1:0];
    endfunction

endpackage

// File: rtl/sinc3_code_map.sv
module sinc3_code_map
    import sinc3_pkg::*;
#(
    parameter int MIN_CODE = 1
) (
    input  code_t      code,
    output frame_cfg_t cfg
);

    localparam code_t FLOOR = code_t'(MIN_CODE);

    assign cfg = decode_code(code, FLOOR);

endmodule

// File: rtl/sinc3_integrators.sv
module sinc3_integrators
    import sinc3_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic take,
    input  logic bit_in,
    output acc_t sum_next
);

    acc_t acc_q [ORDER];
    acc_t acc_d [ORDER];
    acc_t step_in;

    assign step_in = bit_in ? acc_t'(1) : acc_t'(-1);

    always_comb begin
        acc_d[0] = acc_q[0] + step_in;
        for (int s = 1; s < ORDER; s++) begin
            acc_d[s] = acc_q[s] + acc_d[s-1];
        end
    end

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (clr)
                acc_q[g] <= '0;
            else if (take)
                acc_q[g] <= acc_d[g];
        end
    end

    assign sum_next = acc_d[ORDER-1];

endmodule

// File: rtl/sinc3_frame_ctrl.sv
module sinc3_frame_ctrl
    import sinc3_pkg::*;
(
    input  logic   clk,
    input  logic   clr,
    input  logic   take,
    input  ratio_t ratio,
    output logic   last,
    output logic   dec_pulse,
    output logic   settled
);

    ratio_t  cnt_q;
    settle_e st_q;

    assign last    = take && (cnt_q == ratio - ratio_t'(1));
    assign settled = (st_q == SETTLED);

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q     <= '0;
            dec_pulse <= 1'b0;
            st_q      <= FILL_FIRST;
        end else begin
            dec_pulse <= last;
            if (take)
                cnt_q <= last ? '0 : cnt_q + ratio_t'(1);
            if (dec_pulse) begin
                case (st_q)
                    FILL_FIRST:  st_q <= FILL_SECOND;
                    FILL_SECOND: st_q <= SETTLED;
                    default:     st_q <= SETTLED;
                endcase
            end
        end
    end

endmodule

// File: rtl/sinc3_combs.sv
module sinc3_combs
    import sinc3_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic take,
    input  acc_t din,
    output acc_t dout
);

    acc_t dly_q [ORDER];
    acc_t tap   [ORDER+1];

    always_comb begin
        tap[0] = din;
        for (int s = 0; s < ORDER; s++) begin
            tap[s+1] = tap[s] - dly_q[s];
        end
    end

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (clr)
                dly_q[g] <= '0;
            else if (take)
                dly_q[g] <= tap[g];
        end
    end

    assign dout = tap[ORDER];

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
    import sinc3_pkg::*;
#(
    parameter int MIN_CODE   = 1,
    parameter int RESET_CODE = 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_en,
    input  logic                     mod_bit,
    input  logic                     cfg_load,
    input  logic [CODE_W-1:0]        cfg_code,
    output logic signed [OUT_W-1:0]  result,
    output logic                     result_valid,
    output logic                     result_settled
);

    localparam frame_cfg_t RESET_CFG = decode_code(code_t'(RESET_CODE), code_t'(MIN_CODE));

    logic       restart;
    logic       take;
    frame_cfg_t cfg_in;
    frame_cfg_t cfg_q;
    acc_t       int_next;
    acc_t       dec_q;
    acc_t       comb_out;
    logic       last;
    logic       dec_pulse;
    logic       frame_settled;

    assign restart = rst | cfg_load;
    assign take    = sample_en & ~restart;

    sinc3_code_map #(.MIN_CODE(MIN_CODE)) u_map (
        .code (cfg_code),
        .cfg  (cfg_in)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= RESET_CFG;
        else if (cfg_load)
            cfg_q <= cfg_in;
    end

    sinc3_integrators u_int (
        .clk      (clk),
        .clr      (restart),
        .take     (take),
        .bit_in   (mod_bit),
        .sum_next (int_next)
    );

    sinc3_frame_ctrl u_ctrl (
        .clk       (clk),
        .clr       (restart),
        .take      (take),
        .ratio     (cfg_q.ratio),
        .last      (last),
        .dec_pulse (dec_pulse),
        .settled   (frame_settled)
    );

    always_ff @(posedge clk) begin
        if (restart)
            dec_q <= '0;
        else if (last)
            dec_q <= int_next;
    end

    sinc3_combs u_comb (
        .clk  (clk),
        .clr  (restart),
        .take (dec_pulse),
        .din  (dec_q),
        .dout (comb_out)
    );

    always_ff @(posedge clk) begin
        if (restart) begin
            result         <= '0;
            result_valid   <= 1'b0;
            result_settled <= 1'b0;
        end else begin
            result_valid   <= dec_pulse;
            result_settled <= dec_pulse & frame_settled;
            if (dec_pulse)
                result <= scale_out(comb_out, cfg_q);
        end
    end

endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk
    import sinc3_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_en,
    input  logic                     cfg_load,
    input  logic signed [OUT_W-1:0]  result,
    input  logic                     result_valid,
    input  logic                     result_settled
);

    localparam logic signed [OUT_W-1:0] FS_POS = OUT_W'(1 << FS_EXP);

    logic [1:0] vcnt;

    always_ff @(posedge clk) begin
        if (rst || cfg_load)
            vcnt <= 2'd0;
        else if (result_valid && vcnt != 2'd2)
            vcnt <= vcnt + 2'd1;
    end

    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R8
    valid_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> $past(sample_en, 2));

    // R6
    load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (!result_valid && result == '0));

    // R9
    settled_gate_chk: assert property (@(posedge clk) disable iff (rst)
        result_settled |-> result_valid);

    // R9
    settled_order_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (result_settled == (vcnt == 2'd2)));

    // R7
    full_scale_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (result <= FS_POS && result >= -FS_POS));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!result_valid && !$past(cfg_load) && !$past(rst)) |-> $stable(result));

endmodule

bind sinc3_decim sinc3_decim_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .sample_en      (sample_en),
    .cfg_load       (cfg_load),
    .result         (result),
    .result_valid   (result_valid),
    .result_settled (result_settled)
);

// File: tb/sim_sinc3_decim.sv
module sim_sinc3_decim;

    logic              clk = 1'b0;
    logic              rst;
    logic              sample_en;
    logic              mod_bit;
    logic              cfg_load;
    logic [6:0]        cfg_code;
    logic signed [23:0] result;
    logic              result_valid;
    logic              result_settled;

    always #2 clk = ~clk;

    sinc3_decim u0 (
        .clk            (clk),
        .rst            (rst),
        .sample_en      (sample_en),
        .mod_bit        (mod_bit),
        .cfg_load       (cfg_load),
        .cfg_code       (cfg_code),
        .result         (result),
        .result_valid   (result_valid),
        .result_settled (result_settled)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    longint s1, s2, s3;
    longint q0[$];
    longint q1[$];
    longint q2[$];
    int     m_ratio;
    bit     m_left;
    int     m_amt;
    int     m_cnt;
    int     m_nout;
    bit     p1_valid;
    longint p1_val;
    bit     p1_settled;
    bit     e_valid;
    bit     e_settled;
    longint e_result;

    // frame spacing tracking
    int     since;
    bit     prev_strobe;
    bit     seen_valid;
    string  len_tag;
    longint last_val;
    bit     last_settled;

    function automatic int ratio_of(int code);
        int eff;
        eff = (code < 1) ? 1 : code;
        if (eff == 127) return 10240;
        if (eff == 126) return 8533;
        return (eff + 1) * 64;
    endfunction

    function automatic int up_log2(int v);
        int r;
        r = 0;
        while ((1 << r) < v) r++;
        return r;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_restart(int code);
        int total;
        s1 = 0; s2 = 0; s3 = 0;
        q0.delete(); q1.delete(); q2.delete();
        m_ratio = ratio_of(code);
        total   = 3 * up_log2(m_ratio);
        m_left  = (total < 22);
        m_amt   = m_left ? (22 - total) : (total - 22);
        m_cnt = 0; m_nout = 0;
        p1_valid = 0; p1_val = 0; p1_settled = 0;
        e_valid = 0; e_settled = 0; e_result = 0;
    endtask

    task automatic model_edge(bit en, bit b, bit ld, int code, bit rs);
        longint x;
        if (rs) begin model_restart(7); return; end
        if (ld) begin model_restart(code); return; end
        e_valid   = p1_valid;
        e_settled = p1_valid && p1_settled;
        if (p1_valid) e_result = p1_val;
        p1_valid = 0;
        if (en) begin
            x = b ? 1 : -1;
            q0.push_back(x); s1 += x;
            if (q0.size() > m_ratio) s1 -= q0.pop_front();
            q1.push_back(s1); s2 += s1;
            if (q1.size() > m_ratio) s2 -= q1.pop_front();
            q2.push_back(s2); s3 += s2;
            if (q2.size() > m_ratio) s3 -= q2.pop_front();
            m_cnt++;
            if (m_cnt == m_ratio) begin
                m_cnt      = 0;
                p1_valid   = 1;
                p1_val     = m_left ? (s3 <<< m_amt) : (s3 >>> m_amt);
                p1_settled = (m_nout >= 2);
                m_nout++;
            end
        end
    endtask

    task automatic tick(bit en, bit b, bit ld, logic [6:0] code, bit rs);
        rst = rs; sample_en = en; mod_bit = b; cfg_load = ld; cfg_code = code;
        @(posedge clk);
        model_edge(en, b, ld, int'(code), rs);
        cycles++;
        @(negedge clk);
        check(result_valid == e_valid, "R8 valid", longint'(result_valid), longint'(e_valid));
        check(result_settled == e_settled, "R9 settled", longint'(result_settled), longint'(e_settled));
        check(longint'(result) == e_result, result_valid ? "R7 value" : "R10 hold",
              longint'(result), e_result);
        if (rs || ld) begin
            since = 0; prev_strobe = 0; seen_valid = 0;
        end else begin
            since += int'(prev_strobe);
            prev_strobe = en;
            if (result_valid) begin
                if (seen_valid)
                    check(since == m_ratio, len_tag, longint'(since), longint'(m_ratio));
                seen_valid = 1;
                since = 0;
            end
        end
    endtask

    task automatic run_frames(int n, int pat, bit gaps);
        int got;
        got = 0;
        for (int guard = 0; guard < 40000 && got < n; guard++) begin
            bit b;
            bit en;
            case (pat)
                0: b = 1'($urandom % 2);
                1: b = 1'b1;
                2: b = 1'b0;
                default: b = (($urandom % 4) != 0);
            endcase
            en = gaps ? (($urandom % 4) != 0) : 1'b1;
            tick(en, b, 1'b0, 7'd0, 1'b0);
            if (result_valid) begin
                got++;
                last_val = longint'(result);
                last_settled = result_settled;
            end
        end
        check(got == n, "R8 output count", longint'(got), longint'(n));
    endtask

    task automatic load(logic [6:0] code, string tag);
        len_tag = tag;
        tick(1'b1, 1'b1, 1'b1, code, 1'b0);
        // R6: load edge clears the outputs
        check(!result_valid && result == 0, "R6 load clears", longint'(result), 0);
    endtask

    initial begin
        last_val = 0; last_settled = 0; len_tag = "R1";
        since = 0; prev_strobe = 0; seen_valid = 0;
        model_restart(7);
        for (int i = 0; i < 4; i++) tick(1'b1, 1'b1, 1'b0, 7'd0, 1'b1);
        // R1 reset state
        check(result_valid == 0, "R1 valid", longint'(result_valid), 0);
        check(result_settled == 0, "R1 settled", longint'(result_settled), 0);
        check(result == 0, "R1 result", longint'(result), 0);

        len_tag = "R1 default frame";
        run_frames(4, 0, 1'b1);

        load(7'd3, "R2 frame 256");
        run_frames(4, 1, 1'b0);
        // R11 positive full scale
        check(last_val == 4194304, "R11 positive", last_val, 4194304);
        check(last_settled == 1, "R9 third on", longint'(last_settled), 1);

        load(7'd3, "R2 frame 256");
        run_frames(3, 2, 1'b1);
        check(last_val == -4194304, "R11 negative", last_val, -4194304);

        load(7'd0, "R5 floor frame");
        run_frames(3, 0, 1'b0);

        load(7'd5, "R2 frame 384");
        run_frames(3, 0, 1'b1);

        // R6 restart mid-frame, sample offered on load edge
        load(7'd2, "R6 frame 192");
        for (int i = 0; i < 100; i++) tick(1'b1, 1'($urandom % 2), 1'b0, 7'd0, 1'b0);
        load(7'd2, "R6 frame 192");
        run_frames(3, 3, 1'b0);

        load(7'd125, "R2 frame 8064");
        run_frames(3, 3, 1'b0);

        load(7'd126, "R3 frame 8533");
        run_frames(3, 0, 1'b0);

        load(7'd127, "R4 frame 10240");
        run_frames(3, 0, 1'b0);

        // R1 reset in mid-run returns to default code
        for (int i = 0; i < 50; i++) tick(1'b1, 1'b0, 1'b0, 7'd0, 1'b0);
        tick(1'b1, 1'b1, 1'b0, 7'd0, 1'b1);
        check(result == 0 && !result_valid, "R1 mid-run reset", longint'(result), 0);
        len_tag = "R1 default frame";
        run_frames(3, 0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule